// File: doc/BRIEF.md
# Prioritised Interrupt Controller, 32 Sources

This block collects 32 synchronous interrupt request lines and turns them into one interrupt request for a single CPU. Each line has its own detection settings. A line can latch on an edge or follow a level, and it can be active-high or active-low, which for an edge means rising or falling. Each line also has a two-bit priority and its own mask bit. Software can raise any line by writing to a set register. A latched edge stays pending until software clears it.

A read-only identity word reports which pending, unmasked line should be serviced. The winner is the line with the highest priority. Among lines of equal priority, the lowest-numbered line wins. The CPU reaches all state through a single-cycle word-addressed register port. Writes take effect at the next clock edge, and read data is returned combinationally in the cycle the port is selected. The reset input is asynchronous active-low. Its release is synchronised inside the block and takes effect after two clock edges.

Top module: `intc32`

## Requirements
- R1: After reset every mask bit is 1 (blocked). The pending, mode, polarity and priority registers are 0, `irq_o` is 0 and the identity word reads 0x3F.
- R2: A source in edge mode (mode bit 0) sets its pending bit one clock after the sampled input changes. With polarity bit 0 the change must be 0 to 1; with polarity bit 1 it must be 1 to 0. The opposite change sets nothing, and an input held steady does not set the bit again after it is cleared.
- R3: An edge-mode pending bit stays set until a write of 1 to that bit of the pending word (address 0). Writing 0 to the bit leaves it unchanged.
- R4: In level mode (mode bit 1) the pending bit equals the input XOR its polarity bit, so polarity 1 means active-low. A write of 1 to the pending word does not remove a level that is still active.
- R5: A pending source whose mask bit is 1 stays pending but does not drive `irq_o` and cannot win the identity word. Clearing the mask bit (address 1) later exposes it.
- R6: Writing 1 to a bit of the set word (address 2) makes that source pending in either mode. The bit stays pending until it is cleared through the pending word. The set word reads 0.
- R7: `irq_o` is 1 exactly when at least one source is both pending and unmasked.
- R8: The identity word (address 7, bits 5:0) gives the number of the pending, unmasked source with the highest priority, where priority 3 is highest. A tie goes to the lowest source number. When no source qualifies the word reads 0x3F.
- R9: Register map by word address: 0 pending (W1C), 1 mask, 2 set, 3 mode, 4 polarity, 5 priorities of sources 0 to 15, 6 priorities of sources 16 to 31, 7 identity (read-only; writes ignored). In the priority words, source i uses bits 2(i mod 16)+1 to 2(i mod 16). Mask, mode, polarity and priority words read back what was written.
- R10: When an edge arrives in the same cycle as a clearing write to the same bit, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 32 | Synchronous interrupt request lines |
| bus_sel_i | input | 1 | Register port select |
| bus_wr_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while selected |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
Detection is exercised with three input patterns. A rising edge separates the two edge polarities and shows the latch holding after the input drops. A steady line with its pending bit cleared shows that a level is not mistaken for a new edge. An input driven high and then low in level mode, with both polarities, separates a latch from a follower. The identity word is probed with two sources at equal and at unequal priority, and then with the winner masked. This tells a priority comparison apart from index order and shows that the mask is honoured. A directed test drives an edge and its clear into the same cycle to settle which one takes precedence.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int ID_W   = 6;
  localparam logic [ID_W-1:0] ID_NONE = 6'h3F;

  localparam logic [ADDR_W-1:0] A_PEND  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SWSET = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_POL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRIO0 = 3'd5;
  localparam logic [ADDR_W-1:0] A_ID    = 3'd7;
endpackage

// File: rtl/intc_detect.sv
module intc_detect #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] mode_i,
  input  logic [N_SRC-1:0] pol_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] set_i,
  output logic [N_SRC-1:0] pend_o
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic prev_q, prev_d;
    logic lat_q, lat_d, lat_en;
    logic hit;

    always_comb begin
      prev_d = src_i[g];
      hit    = !mode_i[g] && (pol_i[g] ? (prev_q && !src_i[g])
                                       : (!prev_q && src_i[g]));
      lat_en = hit | clr_i[g] | set_i[g];
      lat_d  = hit | set_i[g] | (lat_q & ~clr_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        prev_q <= prev_d;
        if (lat_en) lat_q <= lat_d;
      end
    end

    assign pend_o[g] = lat_q | (mode_i[g] & (src_i[g] ^ pol_i[g]));

    // R2
    edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[g] && !pol_i[g] && !prev_q && src_i[g]) |=> pend_o[g]);

    // R2
    edge_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[g] && pol_i[g] && prev_q && !src_i[g]) |=> pend_o[g]);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_i[g] && pend_o[g] && !clr_i[g]) |=> lat_q);
  end

endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        act_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]         id_o,
  output logic                    valid_o
);

  localparam int IDX_W = $clog2(N_SRC);

  logic [PRIO_W-1:0] prio_a [N_SRC];
  logic [PRIO_W-1:0] best_lvl;
  logic [IDX_W-1:0]  win_idx;
  logic              found;

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    win_idx  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (act_i[i] && (!found || prio_a[i] > best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio_a[i];
        win_idx  = IDX_W'(i);
      end
    end
  end

  assign valid_o = found;
  assign id_o    = found ? ID_W'(win_idx) : ID_NONE;

  // R8
  win_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> act_i[id_o[IDX_W-1:0]]);

  for (genvar g = 0; g < N_SRC; g++) begin : g_chk
    // R8
    prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && act_i[g]) |-> (prio_a[g] <= prio_a[id_o[IDX_W-1:0]]));

    // R8
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && act_i[g] && prio_a[g] == prio_a[id_o[IDX_W-1:0]])
        |-> (IDX_W'(g) >= id_o[IDX_W-1:0]));
  end

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [ID_W-1:0]         id_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [N_SRC-1:0]        mask_o,
  output logic [N_SRC-1:0]        mode_o,
  output logic [N_SRC-1:0]        pol_o,
  output logic [N_SRC*PRIO_W-1:0] prio_o,
  output logic [N_SRC-1:0]        clr_o,
  output logic [N_SRC-1:0]        set_o
);

  localparam int PRIO_BITS  = N_SRC * PRIO_W;
  localparam int PRIO_WORDS = PRIO_BITS / DATA_W;

  logic             wr_en;
  logic             mask_en, mode_en, pol_en;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic [N_SRC-1:0] mode_q, mode_d;
  logic [N_SRC-1:0] pol_q, pol_d;

  assign wr_en   = sel_i & wr_i;
  assign mask_en = wr_en && (addr_i == A_MASK);
  assign mode_en = wr_en && (addr_i == A_MODE);
  assign pol_en  = wr_en && (addr_i == A_POL);

  always_comb begin
    mask_d = wdata_i[N_SRC-1:0];
    mode_d = wdata_i[N_SRC-1:0];
    pol_d  = wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (mode_en) mode_q <= mode_d;
      if (pol_en)  pol_q  <= pol_d;
    end
  end

  for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_pw
    logic              pw_en;
    logic [DATA_W-1:0] pw_q;
    assign pw_en = wr_en && (addr_i == A_PRIO0 + ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pw_q <= '0;
      else if (pw_en) pw_q <= wdata_i;
    end
    assign prio_o[w*DATA_W +: DATA_W] = pw_q;
  end

  assign mask_o = mask_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
  assign clr_o  = (wr_en && addr_i == A_PEND)  ? wdata_i[N_SRC-1:0] : '0;
  assign set_o  = (wr_en && addr_i == A_SWSET) ? wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        A_PEND:  rdata_o[N_SRC-1:0] = pend_i;
        A_MASK:  rdata_o[N_SRC-1:0] = mask_q;
        A_MODE:  rdata_o[N_SRC-1:0] = mode_q;
        A_POL:   rdata_o[N_SRC-1:0] = pol_q;
        A_ID:    rdata_o = {{(DATA_W-ID_W){1'b0}}, id_i};
        default: begin
          for (int w = 0; w < PRIO_WORDS; w++) begin
            if (addr_i == A_PRIO0 + ADDR_W'(w))
              rdata_o = prio_o[w*DATA_W +: DATA_W];
          end
        end
      endcase
    end
  end

  // R9
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_en |=> (mask_o == $past(wdata_i[N_SRC-1:0])));

  // R9
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (mode_o == $past(wdata_i[N_SRC-1:0])));

endmodule

// File: rtl/intc32.sv
module intc32
  import intc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic [1:0]              rs_q, rs_d;
  logic                    rst_sync_n;
  logic [N_SRC-1:0]        pend, mask, mode, pol, clr, set, act;
  logic [N_SRC*PRIO_W-1:0] prio;
  logic [ID_W-1:0]         win_id;
  logic                    win_valid;

  assign rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_sync_n = rs_q[1];

  intc_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend),
    .id_i    (win_id),
    .rdata_o (bus_rdata_o),
    .mask_o  (mask),
    .mode_o  (mode),
    .pol_o   (pol),
    .prio_o  (prio),
    .clr_o   (clr),
    .set_o   (set)
  );

  intc_detect #(.N_SRC(N_SRC)) u_detect (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_i  (irq_src_i),
    .mode_i (mode),
    .pol_i  (pol),
    .clr_i  (clr),
    .set_i  (set),
    .pend_o (pend)
  );

  assign act   = pend & ~mask;
  assign irq_o = |act;

  intc_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .act_i   (act),
    .prio_i  (prio),
    .id_o    (win_id),
    .valid_o (win_valid)
  );

  // R7
  irq_id_agree_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (win_id != ID_NONE));

  // R5
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_valid |-> !mask[win_id[$clog2(N_SRC)-1:0]]);

  // R6
  swset_takes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|set) |=> ((pend & $past(set)) == $past(set)));

endmodule

// File: tb/intc32_test.sv
module intc32_test;
  localparam int NV = 59;
  localparam logic [1:0] K_WR = 2'd0, K_SRC = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intc32 uut (
    .clk(clk), .rst_n(rst_n), .irq_src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // {kind, addr, data, expected, requirement number}
  localparam logic [72:0] VEC [NV] = '{
    {K_RD, 3'd7, 32'h0, 32'h3F, 4'd1},          // R1 identity idle
    {K_RD, 3'd1, 32'h0, 32'hFFFFFFFF, 4'd1},    // R1 masks all set
    {K_RD, 3'd0, 32'h0, 32'h0, 4'd1},           // R1 nothing pending
    {K_RD, 3'd3, 32'h0, 32'h0, 4'd1},           // R1 edge mode
    {K_IRQ, 3'd0, 32'h0, 32'h0, 4'd1},          // R1 irq low
    {K_SRC, 3'd0, 32'h1, 32'h0, 4'd2},
    {K_RD, 3'd0, 32'h0, 32'h1, 4'd2},           // R2 rising latched
    {K_IRQ, 3'd0, 32'h0, 32'h0, 4'd5},          // R5 masked, no irq
    {K_RD, 3'd7, 32'h0, 32'h3F, 4'd5},          // R5 masked, no winner
    {K_WR, 3'd1, 32'hFFFFFFFE, 32'h0, 4'd5},
    {K_IRQ, 3'd0, 32'h0, 32'h1, 4'd7},          // R7 irq up
    {K_RD, 3'd7, 32'h0, 32'h0, 4'd8},           // R8 source 0 wins
    {K_SRC, 3'd0, 32'h0, 32'h0, 4'd2},
    {K_RD, 3'd0, 32'h0, 32'h1, 4'd2},           // R2 falling ignored
    {K_WR, 3'd0, 32'h0, 32'h0, 4'd3},
    {K_RD, 3'd0, 32'h0, 32'h1, 4'd3},           // R3 zero write no effect
    {K_WR, 3'd0, 32'h1, 32'h0, 4'd3},
    {K_RD, 3'd0, 32'h0, 32'h0, 4'd3},           // R3 W1C clears
    {K_IRQ, 3'd0, 32'h0, 32'h0, 4'd7},          // R7 irq down
    {K_RD, 3'd7, 32'h0, 32'h3F, 4'd8},          // R8 none
    {K_WR, 3'd4, 32'h20, 32'h0, 4'd2},
    {K_SRC, 3'd0, 32'h20, 32'h0, 4'd2},
    {K_RD, 3'd0, 32'h0, 32'h0, 4'd2},           // R2 rise ignored when falling pol
    {K_SRC, 3'd0, 32'h0, 32'h0, 4'd2},
    {K_RD, 3'd0, 32'h0, 32'h20, 4'd2},          // R2 fall latched
    {K_WR, 3'd3, 32'h100, 32'h0, 4'd4},
    {K_SRC, 3'd0, 32'h100, 32'h0, 4'd4},
    {K_RD, 3'd0, 32'h0, 32'h120, 4'd4},         // R4 level high follows
    {K_WR, 3'd0, 32'h100, 32'h0, 4'd4},
    {K_RD, 3'd0, 32'h0, 32'h120, 4'd4},         // R4 clear cannot drop live level
    {K_SRC, 3'd0, 32'h0, 32'h0, 4'd4},
    {K_RD, 3'd0, 32'h0, 32'h20, 4'd4},          // R4 level released
    {K_WR, 3'd3, 32'h300, 32'h0, 4'd4},
    {K_WR, 3'd4, 32'h220, 32'h0, 4'd4},
    {K_RD, 3'd0, 32'h0, 32'h220, 4'd4},         // R4 active-low level
    {K_SRC, 3'd0, 32'h200, 32'h0, 4'd4},
    {K_RD, 3'd0, 32'h0, 32'h20, 4'd4},          // R4 active-low released
    {K_WR, 3'd2, 32'h80000000, 32'h0, 4'd6},
    {K_RD, 3'd0, 32'h0, 32'h80000020, 4'd6},    // R6 software raise
    {K_RD, 3'd2, 32'h0, 32'h0, 4'd9},           // R9 set word reads 0
    {K_WR, 3'd1, 32'h0, 32'h0, 4'd8},
    {K_RD, 3'd7, 32'h0, 32'h5, 4'd8},           // R8 tie -> lower index
    {K_WR, 3'd6, 32'h40000000, 32'h0, 4'd8},
    {K_RD, 3'd7, 32'h0, 32'h1F, 4'd8},          // R8 higher level wins
    {K_WR, 3'd5, 32'h400, 32'h0, 4'd8},
    {K_RD, 3'd7, 32'h0, 32'h5, 4'd8},           // R8 tie at level 1
    {K_WR, 3'd5, 32'hC00, 32'h0, 4'd8},
    {K_WR, 3'd6, 32'hC0000000, 32'h0, 4'd8},
    {K_RD, 3'd7, 32'h0, 32'h5, 4'd8},           // R8 tie at level 3
    {K_WR, 3'd1, 32'h20, 32'h0, 4'd5},
    {K_RD, 3'd7, 32'h0, 32'h1F, 4'd5},          // R5 masked winner skipped
    {K_IRQ, 3'd0, 32'h0, 32'h1, 4'd7},          // R7
    {K_RD, 3'd6, 32'h0, 32'hC0000000, 4'd9},    // R9 priority readback
    {K_WR, 3'd7, 32'h0, 32'h0, 4'd9},
    {K_RD, 3'd7, 32'h0, 32'h1F, 4'd9},          // R9 identity write ignored
    {K_WR, 3'd0, 32'h80000020, 32'h0, 4'd6},
    {K_RD, 3'd0, 32'h0, 32'h0, 4'd6},           // R6 software bit cleared
    {K_IRQ, 3'd0, 32'h0, 32'h0, 4'd7},          // R7
    {K_RD, 3'd7, 32'h0, 32'h3F, 4'd8}           // R8
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    check(rdata, exp, req);
    sel = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input int req);
    @(negedge clk);
    #1;
    check({31'b0, irq}, {31'b0, exp}, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][72:71])
        K_WR:    bus_write(VEC[k][70:68], VEC[k][67:36]);
        K_SRC:   drive_src(VEC[k][67:36]);
        K_RD:    read_chk(VEC[k][70:68], VEC[k][35:4], int'(VEC[k][3:0]));
        default: irq_chk(VEC[k][4], int'(VEC[k][3:0]));
      endcase
    end

    // Return every source to rising-edge detection with quiet inputs
    bus_write(3'd3, 32'h0);
    bus_write(3'd4, 32'h0);
    drive_src(32'h0);
    read_chk(3'd0, 32'h0, 2);          // R2 quiet

    // R10: edge and clear of bit 2 in the same cycle
    @(negedge clk);
    src = 32'h4;
    sel = 1'b1; wr = 1'b1; addr = 3'd0; wdata = 32'h4;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    read_chk(3'd0, 32'h4, 10);         // R10 edge wins over clear
    bus_write(3'd0, 32'h4);
    read_chk(3'd0, 32'h0, 3);          // R3 cleared
    repeat (2) @(negedge clk);
    read_chk(3'd0, 32'h0, 2);          // R2 held input does not re-latch

    // R1: reset in mid-run
    drive_src(32'h0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    read_chk(3'd1, 32'hFFFFFFFF, 1);   // R1 masks
    read_chk(3'd0, 32'h0, 1);          // R1 pending
    read_chk(3'd6, 32'h0, 1);          // R1 priorities
    read_chk(3'd7, 32'h3F, 1);         // R1 identity
    irq_chk(1'b0, 1);                  // R1 irq
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule